// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible face of a small LCD controller. A host drives a simple 32-bit read/write port with a byte offset. The bank keeps the panel mode fields, the active width and height, three timing words and a subpanel word. It also holds three sticky status flags that the rest of the controller raises through single-cycle strobes: end of frame, palette loaded and synchronisation error. Every readback word carries fixed padding bits that are always read as one, and each register keeps only its own set of writable bits.

The bank combines the status flags with a two-bit interrupt mask into one level interrupt. The synchronisation error always reaches the interrupt, whatever the mask says. When the host toggles the enable bit, the bank sends a one-cycle start or stop pulse to the fetch engine. It also applies the flag side effects of leaving or entering the running state. Reads are combinational on the offset presented with `rd_en_i`. Writes take effect at the next clock edge.

Top module: `lcd_regbank`

## Requirements
- R1: After reset every field, the width, the height and all flags are zero, and `irq_o`, `start_o`, `stop_o` and `bad_addr_o` are low. Reads then return 0xFE000C34 at 0x00, 0x000003FF at 0x04 and at 0x08, 0xFC000000 at 0x0C, and zero at 0x10 and 0x14.
- R2: A write to offset 0x00 stores the following fields. Bits 21:20 give the palette mode. Bit 7 gives the colour-panel select. Bits 4:3 give the interrupt mask. Bit 1 gives the mono select. Bit 0 gives enable. The word ANDed with 0x01CFF300 is kept as the other control bits. A read of 0x00 returns the OR of these terms: the colour-panel select at bit 23 and again at bit 7, the palette mode at 21:20, the mask at 4:3, mono at 1, enable at 0, the kept bits, and 0xFE000C34. The mode fields also appear on `plm_o`, `tft_o`, `mono_o` and `enable_o`.
- R3: A write to 0x04 sets the width to bits 9:0 plus one and keeps bits 31:10. A read of 0x04 returns the kept bits at 31:10, the low 10 bits of (width − 1) at 9:0, and the value ORed with 0xF. Offset 0x08 handles the height in the same way, but with no OR constant. `width_o` and `height_o` carry the 11-bit values.
- R4: A write to 0x0C stores the whole word, and a read returns it ORed with 0xFC000000. A write to 0x14 stores the word ANDed with 0xA1FFFFFF, and a read returns that stored value.
- R5: A read of 0x10 returns end-of-frame at bit 0, sync error at bit 2 and palette loaded at bit 6, with all other bits zero. Writes to 0x10 change nothing.
- R6: An access to any offset other than the six listed, including unaligned ones, has these results. A read returns zero. A write is dropped. `bad_addr_o` is high for exactly the cycle after that access. `rdata_o` is also zero whenever `rd_en_i` is low.
- R7: Each status strobe input sets its flag at the next edge. The flag then holds until a change of enable clears it.
- R8: In the cycle after any given cycle, `irq_o` equals the OR of three terms from that earlier cycle: (end-of-frame AND mask bit 0), (palette loaded AND mask bit 1), and sync error.
- R9: A control write that changes enable from 0 to 1 clears end-of-frame and palette loaded, and `start_o` is high for the following cycle. A strobe in the same cycle wins over the clear.
- R10: A control write that changes enable from 1 to 0 clears sync error, and `stop_o` is high for the following cycle. The same write sets end-of-frame unless the palette mode it writes is 1, the palette-only mode. A strobe in the same cycle wins over the clear.
- R11: A control write that leaves enable unchanged produces no pulse and leaves the flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| bad_addr_o | output | 1 | Pulses after an access to an undefined offset |
| frame_done_i | input | 1 | End-of-frame strobe |
| palette_done_i | input | 1 | Palette-loaded strobe |
| sync_err_i | input | 1 | Sync-error strobe |
| irq_o | output | 1 | Level interrupt, registered |
| start_o | output | 1 | Start pulse to the fetch engine |
| stop_o | output | 1 | Stop pulse to the fetch engine |
| enable_o | output | 1 | Enable field |
| plm_o | output | 2 | Palette mode field |
| tft_o | output | 1 | Colour-panel select field |
| mono_o | output | 1 | Mono select field |
| width_o | output | 11 | Panel width |
| height_o | output | 11 | Panel height |

## Verification
The bench looks at the disable path taken in palette-only mode. There, a design that sets end-of-frame anyway would raise a frame interrupt that software never asked for. The bench also checks that a sync error interrupts with the mask clear, and that it is cleared by a stop. A design that masks the sync error, or forgets to clear it, would either hide a fault or interrupt forever. The bench checks readback padding and the width minus one directly after reset. There, an off-by-one or a missing constant shows up as a wrong word. It also looks for a strobe that coincides with a start or stop write, where the wrong priority would lose an event. Control writes that do not change enable are checked as well: one that pulses there would restart the fetch engine for no reason.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int unsigned NREG    = 6;
  localparam int unsigned IX_CTRL = 0;
  localparam int unsigned IX_TIM0 = 1;
  localparam int unsigned IX_TIM1 = 2;
  localparam int unsigned IX_TIM2 = 3;
  localparam int unsigned IX_STAT = 4;
  localparam int unsigned IX_SUBP = 5;

  localparam logic [31:0] CTRL_KEEP = 32'h01CF_F300;
  localparam logic [31:0] CTRL_ONES = 32'hFE00_0C34;
  localparam logic [31:0] TIM0_ONES = 32'h0000_000F;
  localparam logic [31:0] TIM2_ONES = 32'hFC00_0000;
  localparam logic [31:0] SUBP_KEEP = 32'hA1FF_FFFF;

  localparam logic [1:0]  PLM_PAL_ONLY = 2'd1;
endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NREG   = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o,
  output logic              hit_o
);
  // word-aligned slot per register
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel_o[g] = (addr_i == ADDR_W'(g * 4));
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/lcdr_status.sv
module lcdr_status
  import lcdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic       en_wr_i,
  input  logic [1:0] plm_wr_i,
  input  logic [1:0] mask_i,
  input  logic       fd_set_i,
  input  logic       pd_set_i,
  input  logic       se_set_i,
  output logic       en_o,
  output logic       fd_o,
  output logic       pd_o,
  output logic       se_o,
  output logic       irq_o,
  output logic       start_o,
  output logic       stop_o
);
  logic en_q, fd_q, pd_q, se_q, irq_q, start_q, stop_q;
  logic go, halt, fd_d, pd_d, se_d;

  assign go   = ctl_wr_i &  en_wr_i & ~en_q;
  assign halt = ctl_wr_i & ~en_wr_i &  en_q;

  // strobes win over clears in the same cycle
  always_comb begin
    fd_d = fd_q;
    pd_d = pd_q;
    se_d = se_q;
    if (go) begin
      fd_d = 1'b0;
      pd_d = 1'b0;
    end
    if (halt) begin
      se_d = 1'b0;
      if (plm_wr_i != PLM_PAL_ONLY) fd_d = 1'b1;
    end
    fd_d |= fd_set_i;
    pd_d |= pd_set_i;
    se_d |= se_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      fd_q    <= 1'b0;
      pd_q    <= 1'b0;
      se_q    <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (ctl_wr_i) en_q <= en_wr_i;
      fd_q    <= fd_d;
      pd_q    <= pd_d;
      se_q    <= se_d;
      irq_q   <= (fd_q & mask_i[0]) | (pd_q & mask_i[1]) | se_q;
      start_q <= go;
      stop_q  <= halt;
    end
  end

  assign en_o    = en_q;
  assign fd_o    = fd_q;
  assign pd_o    = pd_q;
  assign se_o    = se_q;
  assign irq_o   = irq_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;

  p_sync_unmasked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se_q |=> irq_q);
  p_irq_has_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(fd_q | pd_q | se_q));
  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> ((!fd_q || $past(fd_set_i)) && (!pd_q || $past(pd_set_i))));
  p_stop_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> (!se_q || $past(se_set_i)));
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIM_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              bad_addr_o,
  input  logic              frame_done_i,
  input  logic              palette_done_i,
  input  logic              sync_err_i,
  output logic              irq_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              enable_o,
  output logic [1:0]        plm_o,
  output logic              tft_o,
  output logic              mono_o,
  output logic [DIM_W:0]    width_o,
  output logic [DIM_W:0]    height_o
);
  localparam int unsigned TF_W = 32 - DIM_W;

  logic [NREG-1:0] sel;
  logic            hit;
  logic            wr_ctl;
  logic [1:0]      plm_q, mask_q;
  logic            tft_q, mono_q, bad_q;
  logic [31:0]     misc_q, tim2_q, subp_q;
  logic [TF_W-1:0] tim0_q, tim1_q;
  logic [DIM_W:0]  w_q, h_q;
  logic [DIM_W-1:0] wm1, hm1;
  logic            en, fd, pd, se;
  logic [31:0]     rd_val;

  lcdr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  assign wr_ctl = wr_en_i & sel[IX_CTRL];

  lcdr_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_wr_i (wr_ctl),
    .en_wr_i  (wdata_i[0]),
    .plm_wr_i (wdata_i[21:20]),
    .mask_i   (mask_q),
    .fd_set_i (frame_done_i),
    .pd_set_i (palette_done_i),
    .se_set_i (sync_err_i),
    .en_o     (en),
    .fd_o     (fd),
    .pd_o     (pd),
    .se_o     (se),
    .irq_o    (irq_o),
    .start_o  (start_o),
    .stop_o   (stop_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plm_q  <= '0;
      mask_q <= '0;
      tft_q  <= 1'b0;
      mono_q <= 1'b0;
      misc_q <= '0;
      tim0_q <= '0;
      tim1_q <= '0;
      tim2_q <= '0;
      subp_q <= '0;
      w_q    <= '0;
      h_q    <= '0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= (wr_en_i | rd_en_i) & ~hit;
      if (wr_ctl) begin
        plm_q  <= wdata_i[21:20];
        tft_q  <= wdata_i[7];
        mask_q <= wdata_i[4:3];
        mono_q <= wdata_i[1];
        misc_q <= wdata_i & CTRL_KEEP;
      end
      if (wr_en_i && sel[IX_TIM0]) begin
        tim0_q <= wdata_i[31:DIM_W];
        w_q    <= {1'b0, wdata_i[DIM_W-1:0]} + 1'b1;
      end
      if (wr_en_i && sel[IX_TIM1]) begin
        tim1_q <= wdata_i[31:DIM_W];
        h_q    <= {1'b0, wdata_i[DIM_W-1:0]} + 1'b1;
      end
      if (wr_en_i && sel[IX_TIM2]) tim2_q <= wdata_i;
      if (wr_en_i && sel[IX_SUBP]) subp_q <= wdata_i & SUBP_KEEP;
    end
  end

  // low bits of (size - 1); reset value reads as all ones
  assign wm1 = w_q[DIM_W-1:0] - 1'b1;
  assign hm1 = h_q[DIM_W-1:0] - 1'b1;

  always_comb begin
    rd_val = '0;
    if (sel[IX_CTRL])
      rd_val = (32'(tft_q) << 23) | (32'(plm_q) << 20) | (32'(tft_q) << 7)
             | (32'(mask_q) << 3) | (32'(mono_q) << 1) | 32'(en)
             | misc_q | CTRL_ONES;
    else if (sel[IX_TIM0]) rd_val = {tim0_q, wm1} | TIM0_ONES;
    else if (sel[IX_TIM1]) rd_val = {tim1_q, hm1};
    else if (sel[IX_TIM2]) rd_val = tim2_q | TIM2_ONES;
    else if (sel[IX_STAT]) rd_val = (32'(pd) << 6) | (32'(se) << 2) | 32'(fd);
    else if (sel[IX_SUBP]) rd_val = subp_q;
  end

  assign rdata_o    = rd_en_i ? rd_val : '0;
  assign bad_addr_o = bad_q;
  assign enable_o   = en;
  assign plm_o      = plm_q;
  assign tft_o      = tft_q;
  assign mono_o     = mono_q;
  assign width_o    = w_q;
  assign height_o   = h_q;

  p_bad_after_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> $past((wr_en_i | rd_en_i) & ~hit));
  p_stat_wr_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel[IX_STAT] && !frame_done_i && !palette_done_i && !sync_err_i)
      |=> $stable({fd, pd, se}));
  p_pulse_on_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> $past(wr_ctl) && (en != $past(en)));
endmodule

// File: tb/sim_lcd_regbank.sv
module sim_lcd_regbank;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        fs = 1'b0, ps = 1'b0, ss = 1'b0;
  logic [31:0] rdata;
  logic        bad, irq, start, stop, en_o, tft_o, mono_o;
  logic [1:0]  plm_o;
  logic [10:0] width_o, height_o;

  lcd_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .bad_addr_o(bad),
    .frame_done_i(fs), .palette_done_i(ps), .sync_err_i(ss),
    .irq_o(irq), .start_o(start), .stop_o(stop), .enable_o(en_o),
    .plm_o(plm_o), .tft_o(tft_o), .mono_o(mono_o),
    .width_o(width_o), .height_o(height_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [1:0]  m_plm = 0, m_mask = 0;
  logic        m_tft = 0, m_mono = 0, m_en = 0;
  logic [31:0] m_misc = 0, m_t0 = 0, m_t1 = 0, m_t2 = 0, m_sub = 0;
  int          m_w = 0, m_h = 0;
  logic        m_fd = 0, m_pd = 0, m_se = 0;
  logic        m_irq = 0, m_start = 0, m_stop = 0, m_bad = 0;

  function automatic bit known(input logic [7:0] a);
    return a inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14};
  endfunction

  always @(posedge clk) begin : model
    logic nirq, go, halt;
    if (!rst_n) begin
      m_plm = 0; m_mask = 0; m_tft = 0; m_mono = 0; m_en = 0; m_misc = 0;
      m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0; m_w = 0; m_h = 0;
      m_fd = 0; m_pd = 0; m_se = 0; m_irq = 0; m_start = 0; m_stop = 0; m_bad = 0;
    end else begin
      nirq = (m_fd & m_mask[0]) | (m_pd & m_mask[1]) | m_se;
      go = 0; halt = 0;
      m_bad = (wr_en | rd_en) && !known(addr);
      if (wr_en) begin
        case (addr)
          8'h00: begin
            m_plm = wdata[21:20]; m_tft = wdata[7]; m_mask = wdata[4:3];
            m_mono = wdata[1]; m_misc = wdata & 32'h01CFF300;
            if (wdata[0] != m_en) begin
              go = wdata[0]; halt = !wdata[0]; m_en = wdata[0];
            end
          end
          8'h04: begin m_t0 = wdata & 32'hFFFFFC00; m_w = int'(wdata[9:0]) + 1; end
          8'h08: begin m_t1 = wdata & 32'hFFFFFC00; m_h = int'(wdata[9:0]) + 1; end
          8'h0C: m_t2 = wdata;
          8'h14: m_sub = wdata & 32'hA1FFFFFF;
          default: ;
        endcase
      end
      if (go) begin m_fd = 0; m_pd = 0; end
      if (halt) begin m_se = 0; if (m_plm != 2'd1) m_fd = 1; end
      m_fd |= fs; m_pd |= ps; m_se |= ss;
      m_irq = nirq; m_start = go; m_stop = halt;
    end
  end

  function automatic logic [31:0] exp_rd(input logic r, input logic [7:0] a);
    logic [31:0] v;
    if (!r) return 32'h0;
    case (a)
      8'h00: v = (32'(m_tft) << 23) | (32'(m_plm) << 20) | (32'(m_tft) << 7) |
                 (32'(m_mask) << 3) | (32'(m_mono) << 1) | 32'(m_en) | m_misc | 32'hFE000C34;
      8'h04: v = m_t0 | (32'(m_w - 1) & 32'h3FF) | 32'hF;
      8'h08: v = m_t1 | (32'(m_h - 1) & 32'h3FF);
      8'h0C: v = m_t2 | 32'hFC000000;
      8'h10: v = (32'(m_pd) << 6) | (32'(m_se) << 2) | 32'(m_fd);
      8'h14: v = m_sub;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04, 8'h08: return "R3";
      8'h0C, 8'h14: return "R4";
      8'h10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(tag_of(addr), rdata, exp_rd(rd_en, addr));
    chk("R8", 32'(irq), 32'(m_irq));
    chk("R9", 32'(start), 32'(m_start));
    chk("R10", 32'(stop), 32'(m_stop));
    chk("R6", 32'(bad), 32'(m_bad));
    chk("R2", {27'd0, en_o, plm_o, tft_o, mono_o}, {27'd0, m_en, m_plm, m_tft, m_mono});
    chk("R3", {10'd0, width_o, height_o}, {10'd0, 11'(m_w), 11'(m_h)});
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input logic f, input logic p, input logic s);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; fs = f; ps = p; ss = s;
    #1;
    if (rst_n) check_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1, 0, a, d, 0, 0, 0); endtask
  task automatic rd(input logic [7:0] a); cyc(0, 1, a, 0, 0, 0, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset readback
    rd(8'h00); chk("R1", rdata, 32'hFE000C34);
    chk("R1", {28'd0, irq, start, stop, bad}, 32'd0);
    rd(8'h04); chk("R1", rdata, 32'h000003FF);
    rd(8'h08); chk("R1", rdata, 32'h000003FF);
    rd(8'h0C); chk("R1", rdata, 32'hFC000000);
    rd(8'h10); chk("R1", rdata, 32'h0);
    rd(8'h14); chk("R1", rdata, 32'h0);
    // R3 sizes
    wr(8'h04, 32'hABCDE123);
    rd(8'h04); chk("R3", rdata, 32'hABCDE12F); chk("R3", 32'(width_o), 32'h124);
    wr(8'h08, 32'h000003FF);
    rd(8'h08); chk("R3", rdata, 32'h000003FF); chk("R3", 32'(height_o), 32'h400);
    // R4 masks
    wr(8'h0C, 32'h12345678); rd(8'h0C); chk("R4", rdata, 32'hFE345678);
    wr(8'h14, 32'hFFFFFFFF); rd(8'h14); chk("R4", rdata, 32'hA1FFFFFF);
    // R2 / R11: control write keeping enable low
    wr(8'h00, 32'hFFFFFFFE);
    rd(8'h00); chk("R2", rdata, 32'hFFFFFFBE);
    chk("R11", {30'd0, start, stop}, 32'd0);
    // R9 start pulse
    wr(8'h00, 32'h00000019);
    idle(); chk("R9", 32'(start), 32'd1);
    idle(); chk("R9", 32'(start), 32'd0);
    // R7 sticky flag then R8 interrupt one cycle later
    cyc(0, 0, 0, 0, 1, 0, 0);
    rd(8'h10); chk("R7", rdata, 32'h1); chk("R8", 32'(irq), 32'd0);
    idle(); chk("R8", 32'(irq), 32'd1);
    idle(); rd(8'h10); chk("R7", rdata, 32'h1);
    // R11 same-enable write leaves flags
    wr(8'h00, 32'h00000001);
    rd(8'h10); chk("R11", rdata, 32'h1); chk("R11", 32'(start), 32'd0);
    // R10 normal disable sets frame done
    wr(8'h00, 32'h00000000);
    rd(8'h10); chk("R10", rdata, 32'h1); chk("R10", 32'(stop), 32'd1);
    wr(8'h00, 32'h00000001);
    rd(8'h10); chk("R9", rdata, 32'h0);
    // sync error interrupts with mask clear
    cyc(0, 0, 0, 0, 0, 0, 1);
    idle(); idle(); chk("R8", 32'(irq), 32'd1);
    // R5 status write ignored
    wr(8'h10, 32'hFFFFFFFF);
    rd(8'h10); chk("R5", rdata, 32'h4);
    // R10 palette-only disable: sync cleared, frame done stays clear
    wr(8'h00, 32'h00100000);
    rd(8'h10); chk("R10", rdata, 32'h0); chk("R10", 32'(stop), 32'd1);
    // R9 strobe wins over start clear
    cyc(1, 0, 8'h00, 32'h00000001, 1, 1, 0);
    rd(8'h10); chk("R9", rdata, 32'h41);
    // R6 undefined offsets
    wr(8'h18, 32'hFFFFFFFF);
    rd(8'h02); chk("R6", rdata, 32'h0); chk("R6", 32'(bad), 32'd1);
    idle(); chk("R6", 32'(bad), 32'd1);
    idle(); chk("R6", 32'(bad), 32'd0);
    rd(8'h14); chk("R6", rdata, 32'hA1FFFFFF);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: a = 8'h00;
        3: a = 8'h04; 4: a = 8'h08; 5: a = 8'h0C; 6: a = 8'h10; 7: a = 8'h14;
        8: a = 8'h1C;
        default: a = 8'(($urandom_range(0, 63) << 2) | $urandom_range(0, 3));
      endcase
      d = $urandom();
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, a, d,
          $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
          $urandom_range(0, 15) == 0);
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule